// File: doc/BRIEF.md
# Scalar-to-Vector Element Loop Sequencer

This block takes one decoded scalar instruction and repeats it as a hardware loop when a vector mode is active. It emits one micro-operation per vector element. Each micro-operation carries the unchanged operation code. Its destination and source register numbers are advanced by the element index, so successive elements work on successive registers. No vector opcodes exist. The same scalar encoding becomes a short run of element operations, and the execution units downstream see only ordinary scalar work.

Each element keeps a carry bit of its own. These bits live in a bank of 4-bit condition fields. Element 0 draws its carry-in from the scalar carry that came with the instruction. Element k draws its carry-in from bit k of the bank. The execution side writes results back into the bank through a separate write port, one bit per element.

Comparison results are steered to condition field 6 while vector mode is active. Otherwise the field chosen by the decoder is used. When the mode is off, the instruction passes through as exactly one operation.

Top module: `elem_loop_seq`

## Requirements
- R1: With vecMode high at acceptance, one instruction produces N micro-operations, one per cycle while uopReady is high. uopElem runs 0, 1, ..., N-1 in order, and uopOp equals the accepted opIn throughout.
- R2: For element k, uopRd, uopRa and uopRb equal rdIn, raIn and rbIn plus k, modulo 32.
- R3: N is vecLen for vecLen 1 to 8, N is 1 for vecLen 0, and N is 8 for vecLen above 8. A length of 1 produces a single operation with element index 0.
- R4: With vecMode low at acceptance, exactly one micro-operation is produced. Its element index is 0, its register numbers are unmodified, and vecLen has no effect.
- R5: While uopValid is high and uopReady is low, the element index and every micro-operation field hold their values, and no element is consumed.
- R6: done is high in exactly the cycle in which the last element is presented with uopReady high, and low in every other cycle.
- R7: The carry-in for element 0 is the carryIn captured at acceptance. The carry-in for element k>0 is bit k of the carry bank.
- R8: The carry bank resets to all zeros. A cycle with cyWrEn high sets bank bit cyWrIdx to cyWrVal and leaves every other bit unchanged. Bit k sits in field k/4 at position k mod 4.
- R9: uopField is 6 for an instruction accepted with vecMode high, and the captured cmpField otherwise.
- R10: issueReady is high exactly when no run is in progress. An instruction accepted at a clock edge presents element 0 in the following cycle.
- R11: After reset, issueReady is 1 and uopValid and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Decoded scalar instruction offered |
| issueReady | output | 1 | Sequencer idle, instruction accepted this cycle if offered |
| vecMode | input | 1 | Vector mode active for the offered instruction |
| vecLen | input | 4 | Requested element count |
| opIn | input | 8 | Decoded operation code |
| rdIn | input | 5 | Destination register number |
| raIn | input | 5 | First source register number |
| rbIn | input | 5 | Second source register number |
| carryIn | input | 1 | Scalar carry for element 0 |
| cmpField | input | 3 | Condition field chosen by the decoder for scalar comparisons |
| cyWrEn | input | 1 | Carry bank write strobe |
| cyWrIdx | input | 3 | Element whose carry bit is written |
| cyWrVal | input | 1 | Carry value to write |
| uopValid | output | 1 | Micro-operation presented |
| uopReady | input | 1 | Downstream accepts the micro-operation |
| uopOp | output | 8 | Operation code |
| uopRd | output | 5 | Offset destination register |
| uopRa | output | 5 | Offset first source register |
| uopRb | output | 5 | Offset second source register |
| uopElem | output | 3 | Element index |
| uopCarryIn | output | 1 | Carry-in for this element |
| uopField | output | 3 | Condition field for comparison results |
| done | output | 1 | Last element issued this cycle |

## Verification
A wrong element counter shows up as a skipped or repeated register number on uopRd, uopRa or uopRb, or as done in the wrong cycle. The reference model compares these values on every clock, so such a fault is reported in the cycle it first appears. A corrupted carry bank is hidden until a later vector run reads that bit. For this reason the bench writes chosen bits and then issues full-length runs, so each stored bit appears on uopCarryIn one element at a time. Random stalls check that a held element does not advance or change its payload while downstream is not ready.

// File: rtl/elem_loop_pkg.sv
package elem_loop_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new instruction
    logic step;   // current element consumed
    logic last;   // current element is the final one
  } loop_strb_t;
endpackage

// File: rtl/elem_loop_ctrl.sv
module elem_loop_ctrl
  import elem_loop_pkg::*;
#(
  parameter int MAX_VL = 8,
  parameter int LEN_W  = 4,
  localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic             vecMode,
  input  logic [LEN_W-1:0] vecLen,
  input  logic             uopReady,
  output logic             issueReady,
  output logic             uopValid,
  output logic             done,
  output logic [IDX_W-1:0] elemIdx,
  output loop_strb_t       strb
);
  logic             busy;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] lastNext;

  // clamp the requested length to 1..MAX_VL, scalar issue is one element
  always_comb begin
    if (!vecMode || vecLen == '0)
      lastNext = '0;
    else if (vecLen > LEN_W'(MAX_VL))
      lastNext = IDX_W'(MAX_VL - 1);
    else
      lastNext = IDX_W'(vecLen - LEN_W'(1));
  end

  always_comb begin
    strb.load = issueValid && !busy;
    strb.step = busy && uopReady;
    strb.last = busy && (elemIdx == lastIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      elemIdx <= '0;
      lastIdx <= '0;
    end else if (strb.load) begin
      busy    <= 1'b1;
      elemIdx <= '0;
      lastIdx <= lastNext;
    end else if (strb.step) begin
      if (strb.last) begin
        busy    <= 1'b0;
        elemIdx <= '0;
      end else begin
        elemIdx <= elemIdx + IDX_W'(1);
      end
    end
  end

  assign issueReady = !busy;
  assign uopValid   = busy;
  assign done       = strb.step && strb.last;

  // R5: a stalled element stays put
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && !uopReady) |=> (uopValid && $stable(elemIdx)));
  // R6: done only on a consumed element
  a_r6_done_on_step: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (uopValid && uopReady));
  // R10: acceptance starts at element 0 next cycle
  a_r10_accept_start: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady) |=> (uopValid && elemIdx == '0));
  // R3: index never exceeds the clamped length
  a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rstN)
    uopValid |-> (elemIdx <= lastIdx));
  // R6: no done while idle
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !uopValid |-> !done);
endmodule

// File: rtl/elem_loop_dpath.sv
module elem_loop_dpath
  import elem_loop_pkg::*;
#(
  parameter int OP_W      = 8,
  parameter int REG_W     = 5,
  parameter int MAX_VL    = 8,
  parameter int FIELD_W   = 3,
  parameter int VEC_FIELD = 6,
  localparam int IDX_W   = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
  localparam int NFIELD  = (MAX_VL + 3) / 4,
  localparam int FSEL_W  = (NFIELD > 1) ? $clog2(NFIELD) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  loop_strb_t         strb,
  input  logic [IDX_W-1:0]   elemIdx,
  input  logic [OP_W-1:0]    opIn,
  input  logic [REG_W-1:0]   rdIn,
  input  logic [REG_W-1:0]   raIn,
  input  logic [REG_W-1:0]   rbIn,
  input  logic               carryIn,
  input  logic               vecMode,
  input  logic [FIELD_W-1:0] cmpField,
  input  logic               cyWrEn,
  input  logic [IDX_W-1:0]   cyWrIdx,
  input  logic               cyWrVal,
  output logic [OP_W-1:0]    uopOp,
  output logic [REG_W-1:0]   uopRd,
  output logic [REG_W-1:0]   uopRa,
  output logic [REG_W-1:0]   uopRb,
  output logic               uopCarryIn,
  output logic [FIELD_W-1:0] uopField
);
  logic [OP_W-1:0]    opQ;
  logic [REG_W-1:0]   rdQ, raQ, rbQ;
  logic               cyQ, vecQ;
  logic [FIELD_W-1:0] fldQ;
  logic [3:0]         crBank [NFIELD];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ  <= '0;
      rdQ  <= '0;
      raQ  <= '0;
      rbQ  <= '0;
      cyQ  <= 1'b0;
      vecQ <= 1'b0;
      fldQ <= '0;
    end else if (strb.load) begin
      opQ  <= opIn;
      rdQ  <= rdIn;
      raQ  <= raIn;
      rbQ  <= rbIn;
      cyQ  <= carryIn;
      vecQ <= vecMode;
      fldQ <= cmpField;
    end
  end

  // carry bank: one bit per element, packed four to a condition field
  logic [FSEL_W-1:0] wrField, rdField;
  logic [1:0]        wrBit, rdBit;
  assign wrField = FSEL_W'(cyWrIdx >> 2);
  assign wrBit   = 2'(cyWrIdx);
  assign rdField = FSEL_W'(elemIdx >> 2);
  assign rdBit   = 2'(elemIdx);

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rstN)
        crBank[f] <= 4'b0000;
      else if (cyWrEn && wrField == FSEL_W'(f))
        crBank[f][wrBit] <= cyWrVal;
    end
  end

  localparam logic [REG_W-1:0] ONE_REG = REG_W'(1);
  logic [REG_W-1:0] offs;
  assign offs = REG_W'(elemIdx);

  always_comb begin
    uopOp      = opQ;
    uopRd      = rdQ + offs;
    uopRa      = raQ + offs;
    uopRb      = rbQ + offs;
    uopCarryIn = (elemIdx == '0) ? cyQ : crBank[rdField][rdBit];
    uopField   = vecQ ? FIELD_W'(VEC_FIELD) : fldQ;
  end

  // R2: successive elements step every register number by one
  a_r2_reg_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.last) |=>
      (uopRd == $past(uopRd) + ONE_REG && uopRa == $past(uopRa) + ONE_REG &&
       uopRb == $past(uopRb) + ONE_REG));
  // R1: operation code constant across a run
  a_r1_op_steady: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.last) |=> $stable(uopOp));
  // R8: a write lands in the addressed bit
  a_r8_bank_write: assert property (@(posedge clk) disable iff (!rstN)
    cyWrEn |=> (crBank[$past(wrField)][$past(wrBit)] == $past(cyWrVal)));
endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq
  import elem_loop_pkg::*;
#(
  parameter int OP_W      = 8,
  parameter int REG_W     = 5,
  parameter int MAX_VL    = 8,
  parameter int LEN_W     = 4,
  parameter int FIELD_W   = 3,
  parameter int VEC_FIELD = 6,
  localparam int IDX_W   = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  output logic               issueReady,
  input  logic               vecMode,
  input  logic [LEN_W-1:0]   vecLen,
  input  logic [OP_W-1:0]    opIn,
  input  logic [REG_W-1:0]   rdIn,
  input  logic [REG_W-1:0]   raIn,
  input  logic [REG_W-1:0]   rbIn,
  input  logic               carryIn,
  input  logic [FIELD_W-1:0] cmpField,
  input  logic               cyWrEn,
  input  logic [IDX_W-1:0]   cyWrIdx,
  input  logic               cyWrVal,
  output logic               uopValid,
  input  logic               uopReady,
  output logic [OP_W-1:0]    uopOp,
  output logic [REG_W-1:0]   uopRd,
  output logic [REG_W-1:0]   uopRa,
  output logic [REG_W-1:0]   uopRb,
  output logic [IDX_W-1:0]   uopElem,
  output logic               uopCarryIn,
  output logic [FIELD_W-1:0] uopField,
  output logic               done
);
  loop_strb_t       strb;
  logic [IDX_W-1:0] elemIdx;

  elem_loop_ctrl #(.MAX_VL(MAX_VL), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .vecMode(vecMode),
    .vecLen(vecLen), .uopReady(uopReady), .issueReady(issueReady),
    .uopValid(uopValid), .done(done), .elemIdx(elemIdx), .strb(strb)
  );

  elem_loop_dpath #(.OP_W(OP_W), .REG_W(REG_W), .MAX_VL(MAX_VL),
                    .FIELD_W(FIELD_W), .VEC_FIELD(VEC_FIELD)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .elemIdx(elemIdx),
    .opIn(opIn), .rdIn(rdIn), .raIn(raIn), .rbIn(rbIn), .carryIn(carryIn),
    .vecMode(vecMode), .cmpField(cmpField), .cyWrEn(cyWrEn),
    .cyWrIdx(cyWrIdx), .cyWrVal(cyWrVal), .uopOp(uopOp), .uopRd(uopRd),
    .uopRa(uopRa), .uopRb(uopRb), .uopCarryIn(uopCarryIn), .uopField(uopField)
  );

  assign uopElem = elemIdx;
endmodule

// File: tb/elem_loop_seq_bench.sv
`timescale 1ns/1ps
module elem_loop_seq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0, vecMode = 1'b0, carryIn = 1'b0;
  logic [3:0] vecLen = '0;
  logic [7:0] opIn = '0;
  logic [4:0] rdIn = '0, raIn = '0, rbIn = '0;
  logic [2:0] cmpField = '0;
  logic cyWrEn = 1'b0, cyWrVal = 1'b0;
  logic [2:0] cyWrIdx = '0;
  logic uopReady = 1'b1;
  logic issueReady, uopValid, uopCarryIn, done;
  logic [7:0] uopOp;
  logic [4:0] uopRd, uopRa, uopRb;
  logic [2:0] uopElem, uopField;

  always #5 clk = ~clk;

  elem_loop_seq u_elem_loop_seq (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReady(issueReady),
    .vecMode(vecMode), .vecLen(vecLen), .opIn(opIn), .rdIn(rdIn), .raIn(raIn),
    .rbIn(rbIn), .carryIn(carryIn), .cmpField(cmpField), .cyWrEn(cyWrEn),
    .cyWrIdx(cyWrIdx), .cyWrVal(cyWrVal), .uopValid(uopValid),
    .uopReady(uopReady), .uopOp(uopOp), .uopRd(uopRd), .uopRa(uopRa),
    .uopRb(uopRb), .uopElem(uopElem), .uopCarryIn(uopCarryIn),
    .uopField(uopField), .done(done)
  );

  int total = 0, bad = 0, cycles = 0;
  bit stallOn = 0;

  // behavioural reference state
  bit mBusy = 0, mCy = 0, mVec = 0;
  int mElem = 0, mCnt = 1, mOp = 0, mRd = 0, mRa = 0, mRb = 0, mFld = 0;
  bit mBank [8];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // model update at the clock edge
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mBusy = 0; mElem = 0;
      foreach (mBank[i]) mBank[i] = 0;
    end else begin
      if (cyWrEn) mBank[cyWrIdx] = cyWrVal;
      if (mBusy && uopReady) begin
        if (mElem == mCnt - 1) begin mBusy = 0; mElem = 0; end
        else mElem++;
      end else if (!mBusy && issueValid) begin
        mBusy = 1; mElem = 0;
        mCnt = !vecMode ? 1 : (vecLen == 0 ? 1 : (vecLen > 8 ? 8 : int'(vecLen)));
        mOp = opIn; mRd = rdIn; mRa = raIn; mRb = rbIn;
        mCy = carryIn; mVec = vecMode; mFld = cmpField;
      end
    end
  end

  // drive readiness, then compare every cycle away from the edge
  always @(negedge clk) begin
    uopReady = stallOn ? ($urandom % 3 != 0) : 1'b1;
    #1;
    if (rstN) begin
      chk(issueReady == !mBusy, "R10 issueReady", issueReady, !mBusy);
      chk(uopValid == mBusy, "R1 uopValid", uopValid, mBusy);
      chk(done == (mBusy && uopReady && mElem == mCnt - 1), "R6 done", done,
          mBusy && uopReady && mElem == mCnt - 1);
      if (mBusy) begin
        chk(int'(uopElem) == mElem, "R1/R3/R5 uopElem", uopElem, mElem);
        chk(int'(uopOp) == mOp, "R1 uopOp", uopOp, mOp);
        chk(int'(uopRd) == (mRd + mElem) % 32, "R2/R4 uopRd", uopRd, (mRd + mElem) % 32);
        chk(int'(uopRa) == (mRa + mElem) % 32, "R2/R4 uopRa", uopRa, (mRa + mElem) % 32);
        chk(int'(uopRb) == (mRb + mElem) % 32, "R2/R4 uopRb", uopRb, (mRb + mElem) % 32);
        chk(uopCarryIn == (mElem == 0 ? mCy : mBank[mElem]), "R7/R8 uopCarryIn",
            uopCarryIn, mElem == 0 ? mCy : mBank[mElem]);
        chk(int'(uopField) == (mVec ? 6 : mFld), "R9 uopField", uopField, mVec ? 6 : mFld);
      end
    end
  end

  task automatic issue(input bit vm, input int len, input int op, input int rd,
                       input bit cy, input int fld);
    @(negedge clk);
    issueValid = 1; vecMode = vm; vecLen = 4'(len); opIn = 8'(op);
    rdIn = 5'(rd); raIn = 5'(rd + 7); rbIn = 5'(rd + 13); carryIn = cy;
    cmpField = 3'(fld);
    @(negedge clk);
    issueValid = 0; vecLen = 4'(len + 3); vecMode = !vm;
    while (mBusy) @(negedge clk);
  endtask

  task automatic wrCarry(input int idx, input bit v);
    @(negedge clk);
    cyWrEn = 1; cyWrIdx = 3'(idx); cyWrVal = v;
    @(negedge clk);
    cyWrEn = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(issueReady == 1'b1, "R11 reset issueReady", issueReady, 1);
    chk(uopValid == 1'b0, "R11 reset uopValid", uopValid, 0);
    chk(done == 1'b0, "R11 reset done", done, 0);
    @(negedge clk); rstN = 1;
    issue(0, 5, 8'h3c, 3, 1, 1);   // R4 scalar pass-through, length ignored
    issue(1, 4, 8'h41, 10, 0, 0);  // R1 plain vector run
    issue(1, 1, 8'h42, 4, 1, 1);   // R3 length one
    issue(1, 0, 8'h43, 6, 0, 0);   // R3 zero clamps to one
    issue(1, 12, 8'h44, 2, 1, 0);  // R3 over-length clamps to eight
    issue(1, 8, 8'h45, 30, 0, 0);  // R2 register numbers wrap
    wrCarry(2, 1); wrCarry(5, 1); wrCarry(7, 1); wrCarry(0, 1);
    issue(1, 8, 8'h46, 0, 0, 0);   // R7 carries from bank, element 0 scalar
    wrCarry(5, 0); wrCarry(3, 1);
    issue(1, 8, 8'h47, 1, 1, 1);   // R8 single-bit update
    stallOn = 1;
    issue(1, 8, 8'h48, 9, 1, 0);   // R5 random stalls
    issue(0, 8, 8'h49, 17, 0, 2);  // R5 R9 stalled scalar
    issue(1, 6, 8'h4a, 20, 0, 1);
    stallOn = 0;
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule